// File: doc/BRIEF.md
# Strided Two-Direction DMA Engine

This block copies data between a small on-chip scratch memory and a large external memory. The scratch memory has two 4 KB banks, one for data and one for instructions. Software sets up a copy over a simple register bus. It writes a local address with a bank bit, then a 24-bit external byte address, then a packed length word. Writing the length word for one direction launches the copy. The engine then moves 8-byte beats through ready/valid read and write ports on both memories. Each beat is read from the source and then written to the destination.

One length word describes a rectangle. It gives the number of beats in a span, the number of spans, and a gap that is skipped in external memory after each span. The local side stays contiguous and wraps inside its bank. The external side jumps over the gap. The engine holds one running request and one waiting request. It reports busy and full through its status registers. When a copy ends, both address registers hold the address that follows the last beat, so software can chain copies without reprogramming them.

Top module: `strided_dma`

## Requirements
- R1: Register offsets on `reg_addr` are: 0 local address (bit 12 bank, bits 11:0 byte address), 1 external byte address (bits 23:0), 2 external-to-local length, 3 local-to-external length, 4 status (bit 0 busy, bit 1 full), 5 full in bit 0, 6 busy in bit 0. Offsets 2 and 3 read back the last word written. After reset every offset reads zero.
- R2: Bits 2:0 of both address registers are dropped on write and read back as zero. Bits above 12 of offset 0 and above 23 of offset 1 read as zero.
- R3: In a length word, bits 11:3 are the beats per span minus one, bits 19:12 are the spans minus one, and bits 31:23 are the skip in beats. Bits 2:0 and 22:20 are ignored. A zero field means one beat or one span.
- R4: A write to offset 2 launches an external-to-local copy, and a write to offset 3 launches a local-to-external copy. Each copy uses the address registers as they stand in that cycle.
- R5: Beat j of span s uses local beat L0 + s*N + j and external beat E0 + s*(N+K) + j, where N is the beats per span and K the skip. External beats inside the skip gaps are not touched.
- R6: The local beat address wraps modulo 4 KB inside the selected bank. The bank bit drives `loc_rd_bank` and `loc_wr_bank` for the whole copy, and the other bank is not touched.
- R7: A read completes in the cycle where valid and ready are both high, and its data is taken in that cycle. A write completes the same way. Valid, address and data hold until the transfer is accepted. At most one of the four valid outputs is high in any cycle.
- R8: One active and one queued request are held. Full is high while a queued request waits behind an active one. A length write while full is ignored.
- R9: Busy rises in the cycle after an accepted launch. It stays high until the last write of the last request is accepted. A queued request raises its first read valid in the cycle after the previous request's last write is accepted.
- R10: After a copy ends, offset 0 reads the copy's bank and the local address that follows the last beat (modulo 4 KB). Offset 1 reads the external address that follows the last beat, with no skip added after the final span. A software write to an address register in that same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| loc_rd_valid | output | 1 | Scratch memory read request |
| loc_rd_ready | input | 1 | Scratch memory read accept, data valid |
| loc_rd_bank | output | 1 | Read bank (0 data, 1 instruction) |
| loc_rd_addr | output | 12 | Read byte address in bank |
| loc_rd_data | input | 64 | Read beat |
| loc_wr_valid | output | 1 | Scratch memory write request |
| loc_wr_ready | input | 1 | Scratch memory write accept |
| loc_wr_bank | output | 1 | Write bank |
| loc_wr_addr | output | 12 | Write byte address in bank |
| loc_wr_data | output | 64 | Write beat |
| ext_rd_valid | output | 1 | External read request |
| ext_rd_ready | input | 1 | External read accept, data valid |
| ext_rd_addr | output | 24 | External read byte address |
| ext_rd_data | input | 64 | External read beat |
| ext_wr_valid | output | 1 | External write request |
| ext_wr_ready | input | 1 | External write accept |
| ext_wr_addr | output | 24 | External write byte address |
| ext_wr_data | output | 64 | External write beat |

## Verification
The bench builds the block with its package defaults: 4 KB banks, a 24-bit external space, 8-byte beats, a 9-bit beat field and an 8-bit span field. Its external memory model covers 16 KB. It sweeps every combination of 1 to 3 beats, 1 to 3 spans and 0 to 3 skip beats in both directions, with junk in the ignored bits. Pseudo-random ready stalls run throughout. Extra cases cover a bank wrap in the instruction bank, a 256-span copy, and a queue test. In the queue test the readies are held low, so the full flag, the rejected third launch and the chained address writeback can all be observed in a fixed order.

// File: rtl/strided_dma_pkg.sv
package strided_dma_pkg;

    localparam int EXT_AW    = 24;
    localparam int BANK_AW   = 12;
    localparam int DATA_W    = 64;
    localparam int BEAT_SH   = 3;
    localparam int REG_AW    = 4;
    localparam int WORD_W    = 32;

    localparam int LOC_BW    = BANK_AW - BEAT_SH;
    localparam int EXT_BW    = EXT_AW - BEAT_SH;

    localparam int LEN_MSB   = 11;
    localparam int SPAN_LSB  = 12;
    localparam int SPAN_MSB  = 19;
    localparam int SKIP_LSB  = 20 + BEAT_SH;
    localparam int LEN_BW    = LEN_MSB + 1 - BEAT_SH;
    localparam int SPAN_W    = SPAN_MSB - SPAN_LSB + 1;
    localparam int SKIP_BW   = WORD_W - SKIP_LSB;

    localparam logic [REG_AW-1:0] RA_LOC      = 4'd0;
    localparam logic [REG_AW-1:0] RA_EXT      = 4'd1;
    localparam logic [REG_AW-1:0] RA_LEN_IN   = 4'd2;
    localparam logic [REG_AW-1:0] RA_LEN_OUT  = 4'd3;
    localparam logic [REG_AW-1:0] RA_STAT     = 4'd4;
    localparam logic [REG_AW-1:0] RA_FULL     = 4'd5;
    localparam logic [REG_AW-1:0] RA_BUSY     = 4'd6;

    typedef enum logic { DIR_E2L = 1'b0, DIR_L2E = 1'b1 } dir_e;

    typedef enum logic [1:0] { MV_IDLE, MV_READ, MV_WRITE } mv_state_e;

    typedef struct packed {
        dir_e                dir;
        logic                bank;
        logic [LOC_BW-1:0]   loc;
        logic [EXT_BW-1:0]   ext;
        logic [LEN_BW-1:0]   beats_m1;
        logic [SPAN_W-1:0]   spans_m1;
        logic [SKIP_BW-1:0]  skip;
    } xfer_t;

    function automatic xfer_t make_xfer(input dir_e d, input logic bank,
                                        input logic [LOC_BW-1:0] loc,
                                        input logic [EXT_BW-1:0] ext,
                                        input logic [WORD_W-1:0] lw);
        xfer_t x;
        x.dir      = d;
        x.bank     = bank;
        x.loc      = loc;
        x.ext      = ext;
        x.beats_m1 = lw[LEN_MSB:BEAT_SH];
        x.spans_m1 = lw[SPAN_MSB:SPAN_LSB];
        x.skip     = lw[WORD_W-1:SKIP_LSB];
        return x;
    endfunction

endpackage

// File: rtl/sdma_queue.sv
module sdma_queue
    import strided_dma_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  push,
    input  xfer_t push_cmd,
    input  logic  pop,
    input  logic  engine_active,
    output logic  accepted,
    output logic  full,
    output logic  q_valid,
    output xfer_t q_cmd
);

    assign full     = q_valid && engine_active;
    assign accepted = push && !full;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_valid <= 1'b0;
            q_cmd   <= '0;
        end else if (accepted) begin
            q_valid <= 1'b1;
            q_cmd   <= push_cmd;
        end else if (pop) begin
            q_valid <= 1'b0;
        end
    end

    // R8: a launch refused while full leaves the waiting request intact
    a_r8_full_keeps_slot: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (q_valid && $stable(q_cmd)));

    // R8: the engine never takes a request from an empty slot
    a_r8_pop_from_filled: assert property (@(posedge clk) disable iff (rst)
        pop |-> q_valid);

endmodule

// File: rtl/sdma_mover.sv
module sdma_mover
    import strided_dma_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                q_valid,
    input  xfer_t               q_cmd,
    output logic                pop,
    output logic                active,
    output logic                done,
    output dir_e                cur_dir,
    output logic                cur_bank,
    output logic [LOC_BW-1:0]   cur_loc,
    output logic [EXT_BW-1:0]   cur_ext,
    output logic                rd_valid,
    input  logic                rd_ready,
    input  logic [DATA_W-1:0]   rd_data,
    output logic                wr_valid,
    input  logic                wr_ready,
    output logic [DATA_W-1:0]   wr_data
);

    mv_state_e              state;
    logic [LEN_BW-1:0]      beats_m1;
    logic [SKIP_BW-1:0]     skip;
    logic [LEN_BW-1:0]      beat_left;
    logic [SPAN_W-1:0]      span_left;
    logic [DATA_W-1:0]      beat_buf;
    logic                   last_beat;
    logic                   beat_done;

    assign active    = (state != MV_IDLE);
    assign rd_valid  = (state == MV_READ);
    assign wr_valid  = (state == MV_WRITE);
    assign wr_data   = beat_buf;
    assign last_beat = (beat_left == '0) && (span_left == '0);
    assign beat_done = wr_valid && wr_ready;
    assign done      = beat_done && last_beat;
    assign pop       = q_valid && ((state == MV_IDLE) || done);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= MV_IDLE;
            cur_dir   <= DIR_E2L;
            cur_bank  <= 1'b0;
            cur_loc   <= '0;
            cur_ext   <= '0;
            beats_m1  <= '0;
            skip      <= '0;
            beat_left <= '0;
            span_left <= '0;
            beat_buf  <= '0;
        end else if (pop) begin
            state     <= MV_READ;
            cur_dir   <= q_cmd.dir;
            cur_bank  <= q_cmd.bank;
            cur_loc   <= q_cmd.loc;
            cur_ext   <= q_cmd.ext;
            beats_m1  <= q_cmd.beats_m1;
            skip      <= q_cmd.skip;
            beat_left <= q_cmd.beats_m1;
            span_left <= q_cmd.spans_m1;
        end else begin
            unique case (state)
                MV_READ: begin
                    if (rd_ready) begin
                        beat_buf <= rd_data;
                        state    <= MV_WRITE;
                    end
                end
                MV_WRITE: begin
                    if (wr_ready) begin
                        if (last_beat) begin
                            state <= MV_IDLE;
                        end else begin
                            state   <= MV_READ;
                            cur_loc <= cur_loc + 1'b1;
                            if (beat_left == '0) begin
                                beat_left <= beats_m1;
                                span_left <= span_left - 1'b1;
                                cur_ext   <= cur_ext + {{(EXT_BW-SKIP_BW){1'b0}}, skip} + 1'b1;
                            end else begin
                                beat_left <= beat_left - 1'b1;
                                cur_ext   <= cur_ext + 1'b1;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R7: a pending read keeps its address until accepted
    a_r7_read_holds: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(cur_loc) && $stable(cur_ext)));

    // R7: a pending write keeps address and data until accepted
    a_r7_write_holds: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(cur_loc) && $stable(cur_ext)));

    // R6: bank and direction stay fixed while a copy runs
    a_r6_bank_fixed: assert property (@(posedge clk) disable iff (rst)
        (active && !pop) |=> ($stable(cur_bank) && $stable(cur_dir)));

    // R3: the in-span counter never exceeds the programmed span length
    a_r3_beat_bound: assert property (@(posedge clk) disable iff (rst)
        active |-> (beat_left <= beats_m1));

    // R9: a waiting request starts reading right after the previous last write
    a_r9_chain_next_cycle: assert property (@(posedge clk) disable iff (rst)
        (done && q_valid) |=> rd_valid);

endmodule

// File: rtl/strided_dma.sv
module strided_dma
    import strided_dma_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_we,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [WORD_W-1:0]    reg_wdata,
    output logic [WORD_W-1:0]    reg_rdata,
    output logic                 loc_rd_valid,
    input  logic                 loc_rd_ready,
    output logic                 loc_rd_bank,
    output logic [BANK_AW-1:0]   loc_rd_addr,
    input  logic [DATA_W-1:0]    loc_rd_data,
    output logic                 loc_wr_valid,
    input  logic                 loc_wr_ready,
    output logic                 loc_wr_bank,
    output logic [BANK_AW-1:0]   loc_wr_addr,
    output logic [DATA_W-1:0]    loc_wr_data,
    output logic                 ext_rd_valid,
    input  logic                 ext_rd_ready,
    output logic [EXT_AW-1:0]    ext_rd_addr,
    input  logic [DATA_W-1:0]    ext_rd_data,
    output logic                 ext_wr_valid,
    input  logic                 ext_wr_ready,
    output logic [EXT_AW-1:0]    ext_wr_addr,
    output logic [DATA_W-1:0]    ext_wr_data
);

    logic                 loc_bank_q;
    logic [LOC_BW-1:0]    loc_ptr_q;
    logic [EXT_BW-1:0]    ext_ptr_q;
    logic [WORD_W-1:0]    len_in_q;
    logic [WORD_W-1:0]    len_out_q;

    logic                 wr_loc, wr_ext, wr_len_in, wr_len_out, launch;
    xfer_t                launch_cmd, q_cmd;
    logic                 accepted, full, q_valid, pop;
    logic                 mv_active, mv_done, mv_bank, mv_rd_valid, mv_wr_valid;
    logic                 mv_rd_ready, mv_wr_ready;
    dir_e                 mv_dir;
    logic [LOC_BW-1:0]    mv_loc;
    logic [EXT_BW-1:0]    mv_ext;
    logic [DATA_W-1:0]    mv_rd_data, mv_wr_data;
    logic                 busy;

    assign wr_loc     = reg_we && (reg_addr == RA_LOC);
    assign wr_ext     = reg_we && (reg_addr == RA_EXT);
    assign wr_len_in  = reg_we && (reg_addr == RA_LEN_IN);
    assign wr_len_out = reg_we && (reg_addr == RA_LEN_OUT);
    assign launch     = wr_len_in || wr_len_out;
    assign launch_cmd = make_xfer(wr_len_out ? DIR_L2E : DIR_E2L,
                                  loc_bank_q, loc_ptr_q, ext_ptr_q, reg_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            loc_bank_q <= 1'b0;
            loc_ptr_q  <= '0;
            ext_ptr_q  <= '0;
            len_in_q   <= '0;
            len_out_q  <= '0;
        end else begin
            if (wr_loc) begin
                loc_bank_q <= reg_wdata[BANK_AW];
                loc_ptr_q  <= reg_wdata[BANK_AW-1:BEAT_SH];
            end else if (mv_done) begin
                loc_bank_q <= mv_bank;
                loc_ptr_q  <= mv_loc + 1'b1;
            end
            if (wr_ext) begin
                ext_ptr_q <= reg_wdata[EXT_AW-1:BEAT_SH];
            end else if (mv_done) begin
                ext_ptr_q <= mv_ext + 1'b1;
            end
            if (wr_len_in)  len_in_q  <= reg_wdata;
            if (wr_len_out) len_out_q <= reg_wdata;
        end
    end

    sdma_queue u_queue (
        .clk           (clk),
        .rst           (rst),
        .push          (launch),
        .push_cmd      (launch_cmd),
        .pop           (pop),
        .engine_active (mv_active),
        .accepted      (accepted),
        .full          (full),
        .q_valid       (q_valid),
        .q_cmd         (q_cmd)
    );

    sdma_mover u_mover (
        .clk      (clk),
        .rst      (rst),
        .q_valid  (q_valid),
        .q_cmd    (q_cmd),
        .pop      (pop),
        .active   (mv_active),
        .done     (mv_done),
        .cur_dir  (mv_dir),
        .cur_bank (mv_bank),
        .cur_loc  (mv_loc),
        .cur_ext  (mv_ext),
        .rd_valid (mv_rd_valid),
        .rd_ready (mv_rd_ready),
        .rd_data  (mv_rd_data),
        .wr_valid (mv_wr_valid),
        .wr_ready (mv_wr_ready),
        .wr_data  (mv_wr_data)
    );

    assign busy = mv_active || q_valid;

    // Port steering by direction
    assign ext_rd_valid = mv_rd_valid && (mv_dir == DIR_E2L);
    assign loc_rd_valid = mv_rd_valid && (mv_dir == DIR_L2E);
    assign loc_wr_valid = mv_wr_valid && (mv_dir == DIR_E2L);
    assign ext_wr_valid = mv_wr_valid && (mv_dir == DIR_L2E);
    assign mv_rd_ready  = (mv_dir == DIR_E2L) ? ext_rd_ready : loc_rd_ready;
    assign mv_wr_ready  = (mv_dir == DIR_E2L) ? loc_wr_ready : ext_wr_ready;
    assign mv_rd_data   = (mv_dir == DIR_E2L) ? ext_rd_data  : loc_rd_data;
    assign loc_rd_bank  = mv_bank;
    assign loc_wr_bank  = mv_bank;
    assign loc_rd_addr  = {mv_loc, {BEAT_SH{1'b0}}};
    assign loc_wr_addr  = {mv_loc, {BEAT_SH{1'b0}}};
    assign ext_rd_addr  = {mv_ext, {BEAT_SH{1'b0}}};
    assign ext_wr_addr  = {mv_ext, {BEAT_SH{1'b0}}};
    assign loc_wr_data  = mv_wr_data;
    assign ext_wr_data  = mv_wr_data;

    always_comb begin
        unique case (reg_addr)
            RA_LOC:     reg_rdata = WORD_W'({loc_bank_q, loc_ptr_q, {BEAT_SH{1'b0}}});
            RA_EXT:     reg_rdata = WORD_W'({ext_ptr_q, {BEAT_SH{1'b0}}});
            RA_LEN_IN:  reg_rdata = len_in_q;
            RA_LEN_OUT: reg_rdata = len_out_q;
            RA_STAT:    reg_rdata = WORD_W'({full, busy});
            RA_FULL:    reg_rdata = WORD_W'(full);
            RA_BUSY:    reg_rdata = WORD_W'(busy);
            default:    reg_rdata = '0;
        endcase
    end

    // R9: an accepted launch makes the engine busy on the next cycle
    a_r9_busy_after_launch: assert property (@(posedge clk) disable iff (rst)
        accepted |=> busy);

    // R9: busy only drops right after a last write was accepted
    a_r9_busy_falls_on_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(mv_done));

    // R7: never more than one memory request at a time
    a_r7_single_request: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ext_rd_valid, loc_rd_valid, ext_wr_valid, loc_wr_valid}));

    // R8: full implies busy
    a_r8_full_means_busy: assert property (@(posedge clk) disable iff (rst)
        full |-> busy);

endmodule

// File: tb/strided_dma_tb.sv
module strided_dma_tb;
    import strided_dma_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                 rst;
    logic                 reg_we;
    logic [REG_AW-1:0]    reg_addr;
    logic [WORD_W-1:0]    reg_wdata;
    logic [WORD_W-1:0]    reg_rdata;
    logic                 loc_rd_valid, loc_rd_ready, loc_rd_bank;
    logic [BANK_AW-1:0]   loc_rd_addr;
    logic [DATA_W-1:0]    loc_rd_data;
    logic                 loc_wr_valid, loc_wr_ready, loc_wr_bank;
    logic [BANK_AW-1:0]   loc_wr_addr;
    logic [DATA_W-1:0]    loc_wr_data;
    logic                 ext_rd_valid, ext_rd_ready;
    logic [EXT_AW-1:0]    ext_rd_addr;
    logic [DATA_W-1:0]    ext_rd_data;
    logic                 ext_wr_valid, ext_wr_ready;
    logic [EXT_AW-1:0]    ext_wr_addr;
    logic [DATA_W-1:0]    ext_wr_data;

    strided_dma u_dut (
        .clk(clk), .rst(rst),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .loc_rd_valid(loc_rd_valid), .loc_rd_ready(loc_rd_ready), .loc_rd_bank(loc_rd_bank),
        .loc_rd_addr(loc_rd_addr), .loc_rd_data(loc_rd_data),
        .loc_wr_valid(loc_wr_valid), .loc_wr_ready(loc_wr_ready), .loc_wr_bank(loc_wr_bank),
        .loc_wr_addr(loc_wr_addr), .loc_wr_data(loc_wr_data),
        .ext_rd_valid(ext_rd_valid), .ext_rd_ready(ext_rd_ready), .ext_rd_addr(ext_rd_addr),
        .ext_rd_data(ext_rd_data),
        .ext_wr_valid(ext_wr_valid), .ext_wr_ready(ext_wr_ready), .ext_wr_addr(ext_wr_addr),
        .ext_wr_data(ext_wr_data)
    );

    // Memory models
    logic [63:0] bmem [0:1][0:511];
    logic [63:0] emem [0:2047];

    assign loc_rd_data = bmem[loc_rd_bank][loc_rd_addr[11:3]];
    assign ext_rd_data = emem[ext_rd_addr[13:3]];

    always @(posedge clk) begin
        if (loc_wr_valid && loc_wr_ready) bmem[loc_wr_bank][loc_wr_addr[11:3]] <= loc_wr_data;
        if (ext_wr_valid && ext_wr_ready) emem[ext_wr_addr[13:3]] <= ext_wr_data;
    end

    // Pseudo-random ready stalls
    logic [15:0] lfsr = 16'hACE1;
    logic        stall = 1'b0;
    always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    assign ext_rd_ready = !stall && (lfsr[1:0] != 2'b00);
    assign loc_rd_ready = !stall && (lfsr[3:2] != 2'b00);
    assign ext_wr_ready = !stall && (lfsr[5:4] != 2'b00);
    assign loc_wr_ready = !stall && (lfsr[7:6] != 2'b00);

    int n_cmp = 0;
    int n_bad = 0;
    int multi_valid = 0;

    // R7: count cycles with more than one request
    always @(negedge clk) begin
        if (!rst && (int'(loc_rd_valid) + int'(loc_wr_valid) + int'(ext_rd_valid) + int'(ext_wr_valid) > 1))
            multi_valid++;
    end

    function automatic logic [63:0] ext_pat(input int i);
        return {32'hE000_0000 | 32'(i), 32'h0F0F_0000 ^ 32'(i * 7)};
    endfunction

    function automatic logic [63:0] loc_pat(input int b, input int i);
        return {(b != 0) ? 32'h1A00_0000 : 32'hDA00_0000, 32'(i * 3 + 1)};
    endfunction

    task automatic init_mems();
        for (int i = 0; i < 512; i++) begin
            bmem[0][i] = loc_pat(0, i);
            bmem[1][i] = loc_pat(1, i);
        end
        for (int i = 0; i < 2048; i++) emem[i] = ext_pat(i);
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int t = 0; t < 20000; t++) begin
            reg_rd(RA_BUSY, v);
            if (v == 0) break;
        end
    endtask

    function automatic logic [31:0] len_word(input int n, input int s, input int k);
        return (32'(k) << 23) | (32'(s - 1) << 12) | (32'(n - 1) << 3) | 32'h0050_0007;
    endfunction

    // One strided copy with full result check
    task automatic run_case(input bit out_dir, input int bank, input int l0, input int e0,
                            input int n, input int s, input int k);
        logic [31:0] v;
        int li, ei, lend;
        init_mems();
        reg_wr(RA_LOC, 32'((bank << 12) | (l0 * 8) | 5));
        reg_wr(RA_EXT, 32'((e0 * 8) | 3));
        reg_wr(out_dir ? RA_LEN_OUT : RA_LEN_IN, len_word(n, s, k));
        wait_idle();
        for (int sp = 0; sp < s; sp++) begin
            for (int b = 0; b < n; b++) begin
                li = (l0 + sp * n + b) % 512;
                ei = e0 + sp * (n + k) + b;
                if (out_dir) chk("R5 R4 out beat", emem[ei], loc_pat(bank, li));
                else         chk("R5 R4 in beat", bmem[bank][li], ext_pat(ei));
            end
            if (out_dir && sp < s - 1)
                for (int g = 0; g < k; g++)
                    chk("R5 gap untouched", emem[e0 + sp * (n + k) + n + g], ext_pat(e0 + sp * (n + k) + n + g));
        end
        lend = (l0 + s * n) % 512;
        ei   = e0 + (s - 1) * (n + k) + n;
        if (out_dir) chk("R5 beyond end", emem[ei], ext_pat(ei));
        else begin
            chk("R5 beyond end", bmem[bank][lend], loc_pat(bank, lend));
            chk("R6 other bank", bmem[1 - bank][l0], loc_pat(1 - bank, l0));
        end
        reg_rd(RA_LOC, v);
        chk("R10 R2 local readback", 64'(v), 64'((bank << 12) | (lend * 8)));
        reg_rd(RA_EXT, v);
        chk("R10 R2 ext readback", 64'(v), 64'(ei * 8));
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        rst = 1'b1; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        init_mems();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state of every offset
        for (int a = 0; a < 7; a++) begin
            reg_rd(4'(a), v);
            chk("R1 reset value", 64'(v), 64'd0);
        end
        reg_wr(RA_LEN_OUT, 32'h0000_0000);
        reg_wr(RA_LEN_IN, 32'hFFF0_0000);
        wait_idle();
        reg_rd(RA_LEN_IN, v);
        chk("R1 length readback", 64'(v), 64'hFFF0_0000);

        // R3 R4 R5: sweep shapes in both directions
        for (int dir = 0; dir < 2; dir++)
            for (int n = 1; n <= 3; n++)
                for (int s = 1; s <= 3; s++)
                    for (int k = 0; k <= 3; k++)
                        run_case(dir[0], (n + s) % 2, 40 + n * 8 + s, 100 + k * 3 + n, n, s, k);

        // R6: wrap inside the instruction bank
        run_case(1'b0, 1, 510, 300, 4, 1, 0);
        chk("R6 wrap beat0", bmem[1][0], ext_pat(302));
        run_case(1'b1, 1, 509, 600, 2, 2, 1);

        // R3: 256 spans of one beat with a one-beat skip
        run_case(1'b0, 0, 0, 0, 1, 256, 1);

        // R8 R9: queue behaviour with readies held off
        init_mems();
        stall = 1'b1;
        reg_wr(RA_LOC, 32'h0000_0000);
        reg_wr(RA_EXT, 32'h0000_0000);
        reg_wr(RA_LEN_IN, len_word(16, 1, 0));
        reg_rd(RA_BUSY, v);
        chk("R9 busy after launch", 64'(v), 64'd1);
        reg_rd(RA_FULL, v);
        chk("R8 not full with one", 64'(v), 64'd0);
        reg_wr(RA_LOC, 32'h0000_1200);
        reg_wr(RA_EXT, 32'h0000_0400);
        reg_wr(RA_LEN_IN, len_word(4, 1, 0));
        reg_rd(RA_STAT, v);
        chk("R8 status busy and full", 64'(v), 64'd3);
        reg_rd(RA_FULL, v);
        chk("R8 full flag", 64'(v), 64'd1);
        reg_wr(RA_LOC, 32'h0000_0000);
        reg_wr(RA_EXT, 32'h0000_2000);
        reg_wr(RA_LEN_OUT, len_word(2, 1, 0));
        reg_rd(RA_LEN_OUT, v);
        chk("R1 refused length still stored", 64'(v), 64'(len_word(2, 1, 0)));
        stall = 1'b0;
        wait_idle();
        for (int b = 0; b < 16; b++) chk("R8 first copy", bmem[0][b], ext_pat(b));
        for (int b = 0; b < 4; b++)  chk("R8 queued copy", bmem[1][64 + b], ext_pat(128 + b));
        chk("R8 refused copy ignored", emem[1024], ext_pat(1024));
        chk("R8 refused copy ignored", emem[1025], ext_pat(1025));
        reg_rd(RA_LOC, v);
        chk("R10 chained local", 64'(v), 64'h1220);
        reg_rd(RA_EXT, v);
        chk("R10 chained ext", 64'(v), 64'h420);
        reg_rd(RA_STAT, v);
        chk("R9 idle after chain", 64'(v), 64'd0);

        chk("R7 single request", 64'(multi_valid), 64'd0);
        finish_run();
    end

endmodule